// File: doc/BRIEF.md
# Digital Phase-Selecting Clock Recovery

This block recovers timing from an oversampled serial line. Every clock cycle stands for one bit period and brings a vector of `NPH` samples taken at evenly spaced phases of one shared oscillator, with sample 0 the earliest. A phase pointer selects exactly one of those samples as the retimed bit. A bang-bang phase detector finds the single data edge in the vector and judges whether the pointer sits before or after the eye centre. A signed accumulator filters those judgements and moves the pointer by one phase when it saturates, so input jitter is filtered out and the pointer moves only in single-phase steps.

When the line carries no usable edges for a long stretch, the pointer ramps slowly so that it keeps searching for lock. A mode input selects between tracking the data and holding on the reference. In reference mode the line is ignored, the retimed bit stops toggling and the loop state is cleared. A lock flag reports that the pointer has been still for a while.

Top module: `cdr_phase_select`

## Requirements
- R1: After reset `phase_o` is 0, `bit_o` is 0, `bit_vld_o` is 0 and `lock_o` is 0.
- R2: In data mode (`mode_data_i`=1) the clock edge that takes a sample vector sets `bit_o` to `samp_i[phase_o]`, using the pointer value from before that edge, and sets `bit_vld_o` to 1.
- R3: A period holds a valid transition when exactly one adjacent pair (i-1, i), i in 1..NPH-1, differs. The edge index is the first such i. The eye target is (i + NPH/2) mod NPH. The offset is (target - phase) mod NPH, read as signed in -NPH/2..NPH/2-1. A positive offset is an early vote (-1), a negative offset is a late vote (+1), and zero gives no vote.
- R4: A period with no transition or with two or more transitions leaves the accumulator and the pointer unchanged, except for the ramp of R7.
- R5: When the accumulator reaches +ACC_LIM (8) the pointer decrements by one. When it reaches -ACC_LIM it increments by one. The accumulator then clears. `phase_o` changes at the edge that takes the eighth vote, and never by more than one phase per period.
- R6: The pointer wraps modulo NPH (16) in both directions: 0 steps down to 15, and 15 steps up to 0.
- R7: In data mode, once IDLE_LIM (64) consecutive periods have passed without a valid transition, the pointer increments once every RAMP_DIV (4) further such periods, so the first ramp step falls on the 68th period. Any valid transition restarts the count.
- R8: `lock_o` rises at the edge that ends the LOCK_LIM-th (32nd) consecutive data-mode period without a pointer step. It falls at the edge of the next step.
- R9: In reference mode (`mode_data_i`=0) `bit_o` holds, `bit_vld_o` is 0, `phase_o` is frozen and `lock_o` is 0, whatever `samp_i` carries.
- R10: Reference mode clears the accumulator and the idle and quiet counts, so after a return to data mode eight fresh votes are needed for a step and the ramp waits a full IDLE_LIM periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_data_i | input | 1 | 1 = track line data, 0 = hold on reference and ignore the line |
| samp_i | input | NPH | Samples of one bit period; bit i taken at phase i |
| bit_o | output | 1 | Retimed bit |
| bit_vld_o | output | 1 | `bit_o` was taken in data mode this period |
| phase_o | output | $clog2(NPH) | Selected phase index |
| lock_o | output | 1 | Pointer has been still for LOCK_LIM periods |

## Verification
Every output is registered once, so each result is due at the first rising edge after its sample vector is applied. This holds for the retimed bit, the pointer step on the eighth vote, the ramp step on the 68th idle period and the lock flag at the end of the 32nd quiet period. The bench applies each vector at a falling edge and advances its own model on the same vector. It then compares all four outputs at the next falling edge, half a period after the design updates. Directed checks count periods to land on the exact edge of a step, a wrap or a lock change, and they also check the period just before it.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  // Judgement of the phase detector for one bit period
  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_EARLY = 2'd1,
    VOTE_LATE  = 2'd2
  } vote_e;

endpackage

// File: rtl/cdr_phase_det.sv
// Bang-bang detector: finds a single edge in the sample vector and
// compares the selected phase with the eye centre implied by that edge.
module cdr_phase_det
  import cdr_pkg::*;
#(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH)
) (
  input  logic [NPH-1:0] samp_i,
  input  logic [PW-1:0]  phase_i,
  output logic           edge_vld_o,
  output logic [PW-1:0]  edge_pos_o,
  output vote_e          vote_o
);

  localparam logic [PW-1:0] HALF = PW'(NPH / 2);

  logic [NPH-1:1] trans;

  // One transition flag per adjacent sample pair
  genvar gi;
  generate
    for (gi = 1; gi < NPH; gi++) begin : g_pair
      assign trans[gi] = samp_i[gi] ^ samp_i[gi-1];
    end
  endgenerate

  function automatic int edge_count(input logic [NPH-1:1] t);
    int n;
    n = 0;
    for (int i = 1; i < NPH; i++) n += int'(t[i]);
    return n;
  endfunction

  function automatic logic [PW-1:0] first_edge(input logic [NPH-1:1] t);
    logic [PW-1:0] p;
    logic          seen;
    p    = '0;
    seen = 1'b0;
    for (int i = 1; i < NPH; i++) begin
      if (t[i] && !seen) begin
        p    = PW'(i);
        seen = 1'b1;
      end
    end
    return p;
  endfunction

  // Signed distance from the selected phase to the eye centre, modulo NPH
  function automatic logic signed [PW-1:0] eye_offset(input logic [PW-1:0] pos,
                                                      input logic [PW-1:0] ph);
    logic [PW-1:0] tgt;
    tgt = pos + HALF;
    return signed'(tgt - ph);
  endfunction

  logic signed [PW-1:0] offset;

  always_comb begin
    edge_vld_o = (edge_count(trans) == 1);
    edge_pos_o = first_edge(trans);
    offset     = eye_offset(edge_pos_o, phase_i);
    vote_o     = VOTE_NONE;
    if (edge_vld_o) begin
      if (offset > 0)      vote_o = VOTE_EARLY;
      else if (offset < 0) vote_o = VOTE_LATE;
    end
  end

endmodule

// File: rtl/cdr_loop_filter.sv
// Signed accumulator of votes; emits a step request at +/-ACC_LIM.
module cdr_loop_filter
  import cdr_pkg::*;
#(
  parameter int ACC_LIM = 8,
  localparam int AW = $clog2(ACC_LIM) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  vote_e                vote_i,
  output logic                 step_up_o,
  output logic                 step_dn_o,
  output logic signed [AW-1:0] acc_o
);

  localparam logic signed [AW-1:0] ACC_HI = AW'(ACC_LIM - 1);
  localparam logic signed [AW-1:0] ACC_LO = -ACC_HI;

  logic signed [AW-1:0] acc_q;

  // Late votes push up and a full count moves the pointer earlier
  assign step_dn_o = (vote_i == VOTE_LATE)  && (acc_q == ACC_HI) && !clr_i;
  assign step_up_o = (vote_i == VOTE_EARLY) && (acc_q == ACC_LO) && !clr_i;
  assign acc_o     = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr_i || step_up_o || step_dn_o) begin
      acc_q <= '0;
    end else begin
      unique case (vote_i)
        VOTE_LATE:  acc_q <= acc_q + AW'(1);
        VOTE_EARLY: acc_q <= acc_q - AW'(1);
        default:    acc_q <= acc_q;
      endcase
    end
  end

endmodule

// File: rtl/cdr_ramp_gen.sv
// Counts periods without a usable edge; once idle, requests a slow ramp.
module cdr_ramp_gen #(
  parameter int IDLE_LIM = 64,
  parameter int RAMP_DIV = 4,
  localparam int IW = $clog2(IDLE_LIM + 1),
  localparam int RW = $clog2(RAMP_DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic edge_vld_i,
  output logic ramp_step_o
);

  logic [IW-1:0] idle_q;
  logic [RW-1:0] div_q;
  logic          idle_full;
  logic          quiet_period;

  assign idle_full    = (idle_q == IW'(IDLE_LIM));
  assign quiet_period = en_i && !edge_vld_i;
  assign ramp_step_o  = quiet_period && idle_full && (div_q == RW'(RAMP_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      div_q  <= '0;
    end else if (!quiet_period) begin
      idle_q <= '0;
      div_q  <= '0;
    end else if (!idle_full) begin
      idle_q <= idle_q + IW'(1);
    end else if (ramp_step_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + RW'(1);
    end
  end

endmodule

// File: rtl/cdr_lock_mon.sv
// Flags lock after LOCK_LIM consecutive periods without a pointer step.
module cdr_lock_mon #(
  parameter int LOCK_LIM = 32,
  localparam int QW = $clog2(LOCK_LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic step_i,
  output logic lock_o
);

  logic [QW-1:0] quiet_q;
  logic [QW-1:0] quiet_nxt;

  assign quiet_nxt = (quiet_q == QW'(LOCK_LIM)) ? quiet_q : quiet_q + QW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      lock_o  <= 1'b0;
    end else if (!en_i || step_i) begin
      quiet_q <= '0;
      lock_o  <= 1'b0;
    end else begin
      quiet_q <= quiet_nxt;
      lock_o  <= (quiet_nxt == QW'(LOCK_LIM));
    end
  end

endmodule

// File: rtl/cdr_phase_select.sv
// Top: phase pointer, retiming register and the loop around them.
// NPH must be a power of two so that pointer arithmetic wraps naturally.
module cdr_phase_select
  import cdr_pkg::*;
#(
  parameter int NPH      = 16,
  parameter int ACC_LIM  = 8,
  parameter int IDLE_LIM = 64,
  parameter int RAMP_DIV = 4,
  parameter int LOCK_LIM = 32,
  localparam int PW = $clog2(NPH),
  localparam int AW = $clog2(ACC_LIM) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_data_i,
  input  logic [NPH-1:0] samp_i,
  output logic           bit_o,
  output logic           bit_vld_o,
  output logic [PW-1:0]  phase_o,
  output logic           lock_o
);

  // Internal events, named for the checker
  logic                 edge_vld;
  logic [PW-1:0]        edge_pos;
  vote_e                vote_raw;
  vote_e                vote_g;
  logic                 step_up;
  logic                 step_dn;
  logic                 ramp_step;
  logic                 any_step;
  logic signed [AW-1:0] filt_acc;
  logic [PW-1:0]        phase_q;

  cdr_phase_det #(.NPH(NPH)) u_det (
    .samp_i     (samp_i),
    .phase_i    (phase_q),
    .edge_vld_o (edge_vld),
    .edge_pos_o (edge_pos),
    .vote_o     (vote_raw)
  );

  assign vote_g = mode_data_i ? vote_raw : VOTE_NONE;

  cdr_loop_filter #(.ACC_LIM(ACC_LIM)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (!mode_data_i),
    .vote_i    (vote_g),
    .step_up_o (step_up),
    .step_dn_o (step_dn),
    .acc_o     (filt_acc)
  );

  cdr_ramp_gen #(.IDLE_LIM(IDLE_LIM), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (mode_data_i),
    .edge_vld_i  (edge_vld),
    .ramp_step_o (ramp_step)
  );

  assign any_step = step_up || step_dn || ramp_step;

  cdr_lock_mon #(.LOCK_LIM(LOCK_LIM)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (mode_data_i),
    .step_i (any_step),
    .lock_o (lock_o)
  );

  // Phase pointer, modulo NPH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (mode_data_i) begin
      if (step_dn)                    phase_q <= phase_q - PW'(1);
      else if (step_up || ramp_step)  phase_q <= phase_q + PW'(1);
    end
  end

  // Retiming register: holds in reference mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= mode_data_i;
      if (mode_data_i) bit_o <= samp_i[phase_q];
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/cdr_phase_select_chk.sv
module cdr_phase_select_chk #(
  parameter int NPH     = 16,
  parameter int ACC_LIM = 8,
  localparam int PW = $clog2(NPH),
  localparam int AW = $clog2(ACC_LIM) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_data_i,
  input logic [NPH-1:0]       samp_i,
  input logic                 bit_o,
  input logic                 bit_vld_o,
  input logic [PW-1:0]        phase_o,
  input logic                 lock_o,
  input logic                 edge_vld,
  input logic                 step_up,
  input logic                 step_dn,
  input logic                 ramp_step,
  input logic signed [AW-1:0] filt_acc
);

  AST_RETIME_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_data_i |=> (bit_vld_o && bit_o == $past(samp_i[phase_o]))); // R2

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_data_i |=> ($stable(bit_o) && !bit_vld_o && $stable(phase_o) && !lock_o)); // R9

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_o == $past(phase_o) || phase_o == PW'($past(phase_o) + PW'(1))
              || phase_o == PW'($past(phase_o) - PW'(1)))); // R6

  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, ramp_step})); // R5

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(filt_acc) < ACC_LIM) && (int'(filt_acc) > -ACC_LIM)); // R5

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_vld && !ramp_step) |=> $stable(phase_o)); // R4

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn || ramp_step) |=> !lock_o); // R8

  AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_step |-> (!edge_vld && mode_data_i)); // R7

endmodule

bind cdr_phase_select cdr_phase_select_chk #(.NPH(NPH), .ACC_LIM(ACC_LIM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_data_i (mode_data_i),
  .samp_i      (samp_i),
  .bit_o       (bit_o),
  .bit_vld_o   (bit_vld_o),
  .phase_o     (phase_o),
  .lock_o      (lock_o),
  .edge_vld    (edge_vld),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .ramp_step   (ramp_step),
  .filt_acc    (filt_acc)
);

// File: tb/cdr_phase_select_tb.sv
`timescale 1ns/1ps
module cdr_phase_select_tb;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b1;
  logic [N-1:0] samp = '0;
  logic         bit_o, bit_vld_o, lock_o;
  logic [3:0]   phase_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  cdr_phase_select u_dut (
    .clk (clk), .rst_n (rst_n), .mode_data_i (mode), .samp_i (samp),
    .bit_o (bit_o), .bit_vld_o (bit_vld_o), .phase_o (phase_o), .lock_o (lock_o)
  );

  // Watchdog
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act %0d cycles exp below 150000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Behavioural model, written from the requirements
  int m_phase, m_acc, m_idle, m_div, m_quiet, m_lock, m_bit, m_vld;

  function automatic int edges_in(input logic [N-1:0] s, output int pos);
    int n;
    n = 0; pos = 0;
    for (int i = 1; i < N; i++)
      if (s[i] != s[i-1]) begin
        n++;
        if (n == 1) pos = i;
      end
    return n;
  endfunction

  function automatic int wrap_signed(input int v);
    int d;
    d = ((v % N) + N) % N;
    if (d >= N/2) d -= N;
    return d;
  endfunction

  function automatic logic [N-1:0] mk_vec(input int k, input logic pol);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i < k) ? pol : ~pol;
    return v;
  endfunction

  task automatic model_step(input logic [N-1:0] s, input logic md);
    int pos, ne, d;
    bit stepped;
    stepped = 0;
    if (md) begin
      m_bit = int'(s[m_phase]);
      m_vld = 1;
      ne = edges_in(s, pos);
      if (ne == 1) begin
        m_idle = 0; m_div = 0;
        d = wrap_signed((pos + N/2) - m_phase);
        if (d > 0) m_acc--;
        else if (d < 0) m_acc++;
        if (m_acc == 8)       begin m_phase = (m_phase + N - 1) % N; m_acc = 0; stepped = 1; end
        else if (m_acc == -8) begin m_phase = (m_phase + 1) % N;     m_acc = 0; stepped = 1; end
      end else begin
        if (m_idle < 64) m_idle++;
        else if (m_div == 3) begin m_div = 0; m_phase = (m_phase + 1) % N; stepped = 1; end
        else m_div++;
      end
      if (stepped) begin m_quiet = 0; m_lock = 0; end
      else begin
        if (m_quiet < 32) m_quiet++;
        m_lock = (m_quiet >= 32) ? 1 : 0;
      end
    end else begin
      m_vld = 0; m_acc = 0; m_idle = 0; m_div = 0; m_quiet = 0; m_lock = 0;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  // One bit period: drive at a falling edge, compare at the next one
  task automatic period(input logic [N-1:0] s, input logic md);
    samp = s; mode = md;
    model_step(s, md);
    @(posedge clk);
    @(negedge clk);
    chk("R2", int'(bit_o), m_bit, "bit_o");
    chk("R9", int'(bit_vld_o), m_vld, "bit_vld_o");
    chk("R5", int'(phase_o), m_phase, "phase_o");
    chk("R8", int'(lock_o), m_lock, "lock_o");
  endtask

  initial begin
    logic held_bit;
    void'($urandom(32'h5EED_0042));
    m_phase = 0; m_acc = 0; m_idle = 0; m_div = 0;
    m_quiet = 0; m_lock = 0; m_bit = 0; m_vld = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(phase_o), 0, "reset phase");
    chk("R1", int'(bit_o), 0, "reset bit");
    chk("R1", int'(bit_vld_o), 0, "reset valid");
    chk("R1", int'(lock_o), 0, "reset lock");
    rst_n = 1'b1;

    // R3/R5: edge at 11 -> target 3, early votes raise the pointer
    for (int i = 1; i <= 24; i++) begin
      period(mk_vec(11, i[0]), 1'b1);
      if (i == 7)  chk("R5", int'(phase_o), 0, "no step before 8th vote");
      if (i == 8)  chk("R3", int'(phase_o), 1, "early votes step up");
      if (i == 24) chk("R5", int'(phase_o), 3, "pointer at eye centre");
    end
    // R8: lock after 32 still periods
    for (int i = 1; i <= 32; i++) begin
      period(mk_vec(11, 1'b0), 1'b1);
      if (i == 31) chk("R8", int'(lock_o), 0, "lock before 32");
      if (i == 32) chk("R8", int'(lock_o), 1, "lock at 32");
    end
    chk("R3", int'(phase_o), 3, "centred edge gives no vote");

    // R4: late votes (target 1) broken by invalid periods
    for (int i = 0; i < 7; i++) period(mk_vec(9, 1'b1), 1'b1);
    for (int i = 0; i < 20; i++) period(16'h0FF0, 1'b1);
    for (int i = 0; i < 20; i++) period(16'hFFFF, 1'b1);
    chk("R4", int'(phase_o), 3, "invalid periods ignored");
    period(mk_vec(9, 1'b0), 1'b1);
    chk("R4", int'(phase_o), 2, "8th late vote steps down");
    chk("R8", int'(lock_o), 0, "lock drops on step");

    // R6: downward wrap, target 14
    for (int i = 1; i <= 32; i++) begin
      period(mk_vec(6, 1'b1), 1'b1);
      if (i == 16) chk("R6", int'(phase_o), 0, "reach 0");
      if (i == 24) chk("R6", int'(phase_o), 15, "wrap 0 to 15");
    end
    chk("R6", int'(phase_o), 14, "settled at 14");

    // R7: ramp after 64 idle periods, every 4 after
    for (int i = 1; i <= 72; i++) begin
      period(16'h0000, 1'b1);
      if (i == 67) chk("R7", int'(phase_o), 14, "no ramp before 68");
      if (i == 68) chk("R7", int'(phase_o), 15, "first ramp step");
      if (i == 71) chk("R7", int'(phase_o), 15, "ramp spacing");
      if (i == 72) chk("R6", int'(phase_o), 0, "ramp wraps 15 to 0");
    end

    // R9/R10: partial state, reference mode, then resume
    for (int i = 0; i < 5; i++) period(mk_vec(6, 1'b0), 1'b1);
    for (int i = 0; i < 60; i++) period(16'h0000, 1'b1);
    held_bit = bit_o;
    for (int i = 0; i < 10; i++) begin
      period(16'($urandom), 1'b0);
      chk("R9", int'(bit_o), int'(held_bit), "bit held in reference mode");
      chk("R9", int'(phase_o), 0, "phase frozen in reference mode");
      chk("R9", int'(lock_o), 0, "no lock in reference mode");
    end
    for (int i = 0; i < 10; i++) period(16'hFFFF, 1'b1);
    chk("R10", int'(phase_o), 0, "idle count restarted");
    for (int i = 0; i < 7; i++) period(mk_vec(6, 1'b1), 1'b1);
    chk("R10", int'(phase_o), 0, "accumulator restarted");
    period(mk_vec(6, 1'b1), 1'b1);
    chk("R10", int'(phase_o), 15, "fresh 8th vote steps");

    // Random mix checked against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic md;
      r  = int'($urandom % 10);
      md = ($urandom % 25) != 0;
      if (i >= 1500 && i < 1600) period({N{i[0]}}, 1'b1);
      else if (r < 5) period(mk_vec(1 + int'($urandom % 15), 1'($urandom)), md);
      else if (r < 7) period({N{1'($urandom)}}, md);
      else period(16'($urandom), md);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule